// File: doc/BRIEF.md
# Gate-Qualified Single-Clock FIFO

This block is a first-in first-out queue of signed elements on one clock. Every state-changing action on it (accepting an element, removing the oldest element, emptying the queue) is permitted only while an effective gate is on. The gate is a synchronous enable, not a gated clock. It is built as a chain: a base enable is ANDed with the first level enable, and each later level ANDs one more enable onto the level beneath it. The top of the chain is the effective gate.

While the effective gate is off, the queue is frozen. All three action handshakes report not-ready and requests on them are dropped. The read-only view of the oldest element, and the flag saying that such an element exists, remain valid through the gate-off period. A consumer can therefore keep inspecting the head while the queue is paused. The full chain of gate levels is brought out, so that logic around the block can see which level is holding it off.

Top module: `gated_fifo`

## Requirements
- R1: `gate_chain[0]` equals `base_en & lvl_en[0]`, and `gate_chain[i]` equals `gate_chain[i-1] & lvl_en[i]` for i ≥ 1. The effective gate is `gate_chain[LEVELS-1]`.
- R2: Whenever a gate level is on, every level below it in the chain is also on.
- R3: `enq_ready` is high exactly when the effective gate is on and fewer than DEPTH entries are held. `deq_ready` is high exactly when the gate is on and at least one entry is held. `clr_ready` equals the effective gate.
- R4: While the effective gate is off, enqueue, dequeue and clear requests are ignored. The held entries, their order, `head_valid` and `head_data` are unchanged at the next edge.
- R5: `head_valid` is high exactly when the queue holds at least one entry, whatever the gate state.
- R6: An element is accepted at a rising edge where `enq_valid & enq_ready`, and it is removed at an edge where `deq_req & deq_ready`. `head_data` always shows the oldest held element, and elements leave in arrival order with their signed value unchanged (default 3-bit two's complement, -4 to 3).
- R7: With DEPTH entries held, a simultaneous enqueue and dequeue request removes the head but does not accept the new element.
- R8: A clear (`clr_req & clr_ready`) empties the queue at the next edge. Any enqueue or dequeue requested in the same cycle has no effect.
- R9: With `rst_n` low at a rising edge, the queue is empty after that edge, whatever the gate state.
- R10: A simultaneous accepted enqueue and dequeue on a queue that is neither empty nor full keeps the entry count and appends the new element behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_en | input | 1 | Base enable at the bottom of the gate chain |
| lvl_en | input | LEVELS | Per-level enables layered onto the base |
| enq_valid | input | 1 | Enqueue request |
| enq_data | input | W | Signed element to enqueue |
| enq_ready | output | 1 | Enqueue may be taken this cycle |
| deq_req | input | 1 | Dequeue request |
| deq_ready | output | 1 | Dequeue may be taken this cycle |
| head_valid | output | 1 | Queue holds at least one entry |
| head_data | output | W | Oldest held element (signed) |
| clr_req | input | 1 | Clear request |
| clr_ready | output | 1 | Clear may be taken this cycle |
| gate_chain | output | LEVELS | Composed gate of every level |

## Verification
The readies and the gate chain are combinational. They are due in the same cycle as the inputs and are sampled one nanosecond after the falling edge on which those inputs are driven. Queue state (`head_valid`, `head_data`) changes one rising edge after an accepted action, clear or reset. The bench applies each action to its queue model at that rising edge and compares the model against the outputs at the next falling-edge sample. A gate-off cycle is therefore checked as frozen state exactly one edge later.

// File: rtl/gfifo_pkg.sv
// Package: shared types for the gate-qualified FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package gfifo_pkg;

    // Actions that take effect at the coming rising edge.
    typedef struct packed {
        logic clr;
        logic enq;
        logic deq;
    } gfifo_act_t;

endpackage

// File: rtl/gfifo_gate_chain.sv
// Module: composes the nested gate levels. Level 0 is the base enable
// ANDed with the first level enable; each further level ANDs its own
// enable onto the level beneath it.
// Assumes: LEVELS >= 1; all inputs synchronous to the block clock.
module gfifo_gate_chain #(
    parameter int LEVELS = 2
) (
    input  logic              base_en,
    input  logic [LEVELS-1:0] lvl_en,
    output logic [LEVELS-1:0] chain
);

    // Bottom level: base enable qualified by the first level enable.
    always_comb chain[0] = base_en & lvl_en[0];

    genvar g;
    generate
        for (g = 1; g < LEVELS; g++) begin : g_lvl
            // Each derived level is its parent ANDed with its own enable.
            always_comb chain[g] = chain[g-1] & lvl_en[g];
        end
    endgenerate

endmodule

// File: rtl/gfifo_ctrl.sv
// Module: pointer control for the FIFO. The read and write pointers carry
// one wrap bit beyond the address, so full and empty follow from comparing
// them. Every action is qualified by the effective gate. Clear outranks
// enqueue and dequeue.
// Assumes: DEPTH is a power of two, DEPTH >= 2; synchronous active-low reset.
module gfifo_ctrl
    import gfifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          enq_valid,
    input  logic          deq_req,
    input  logic          clr_req,
    output logic          enq_ready,
    output logic          deq_ready,
    output logic          clr_ready,
    output logic          empty,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);

    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    logic        full;
    gfifo_act_t  act;

    // Occupancy flags from the wrap-extended pointers.
    always_comb begin
        empty = (wr_ptr == rd_ptr);
        full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    end

    // Handshake readies, all masked by the effective gate.
    always_comb begin
        enq_ready = gate & ~full;
        deq_ready = gate & ~empty;
        clr_ready = gate;
    end

    // Resolve the actions of this cycle; clear suppresses the other two.
    always_comb begin
        act.clr = clr_req & clr_ready;
        act.enq = enq_valid & enq_ready & ~act.clr;
        act.deq = deq_req & deq_ready & ~act.clr;
    end

    // Storage addressing derived from the pointers.
    always_comb begin
        wr_en   = act.enq;
        wr_addr = wr_ptr[AW-1:0];
        rd_addr = rd_ptr[AW-1:0];
    end

    // Pointer update: reset and clear empty the queue, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n || act.clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (act.enq) wr_ptr <= wr_ptr + 1'b1;
            if (act.deq) rd_ptr <= rd_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/gfifo_store.sv
// Module: element storage with one synchronous write port and one
// asynchronous read port for the head view.
// Assumes: write enable already carries gate and fullness qualification.
module gfifo_store #(
    parameter int W     = 3,
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic signed [W-1:0] wr_data,
    input  logic [AW-1:0]       rd_addr,
    output logic signed [W-1:0] rd_data
);

    logic signed [W-1:0] mem [DEPTH];

    // Write the accepted element into its slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the slot at the read pointer.
    always_comb rd_data = mem[rd_addr];

endmodule

// File: rtl/gated_fifo.sv
// Module: top of the gate-qualified FIFO. Builds the gate chain, drives
// pointer control with the effective gate and exposes the head view,
// which stays valid whatever the gate does.
// Assumes: single clock; DEPTH power of two >= 2; LEVELS >= 1.
module gated_fifo #(
    parameter int W      = 3,
    parameter int DEPTH  = 4,
    parameter int LEVELS = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                base_en,
    input  logic [LEVELS-1:0]   lvl_en,
    input  logic                enq_valid,
    input  logic signed [W-1:0] enq_data,
    output logic                enq_ready,
    input  logic                deq_req,
    output logic                deq_ready,
    output logic                head_valid,
    output logic signed [W-1:0] head_data,
    input  logic                clr_req,
    output logic                clr_ready,
    output logic [LEVELS-1:0]   gate_chain
);

    logic          gate_eff;
    logic          empty;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    gfifo_gate_chain #(.LEVELS(LEVELS)) u_gate (
        .base_en (base_en),
        .lvl_en  (lvl_en),
        .chain   (gate_chain)
    );

    // The effective gate is the top of the chain.
    always_comb gate_eff = gate_chain[LEVELS-1];

    gfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate_eff),
        .enq_valid (enq_valid),
        .deq_req   (deq_req),
        .clr_req   (clr_req),
        .enq_ready (enq_ready),
        .deq_ready (deq_ready),
        .clr_ready (clr_ready),
        .empty     (empty),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr)
    );

    gfifo_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (enq_data),
        .rd_addr (rd_addr),
        .rd_data (head_data)
    );

    // Head validity ignores the gate.
    always_comb head_valid = ~empty;

endmodule

// File: rtl/gated_fifo_chk.sv
// Module: property checker bound to gated_fifo.
// Assumes: synchronous active-low reset driven low from time zero.
module gated_fifo_chk #(
    parameter int W      = 3,
    parameter int DEPTH  = 4,
    parameter int LEVELS = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                base_en,
    input logic [LEVELS-1:0]   lvl_en,
    input logic                enq_valid,
    input logic signed [W-1:0] enq_data,
    input logic                enq_ready,
    input logic                deq_req,
    input logic                deq_ready,
    input logic                head_valid,
    input logic signed [W-1:0] head_data,
    input logic                clr_req,
    input logic                clr_ready,
    input logic [LEVELS-1:0]   gate_chain
);

    genvar g;
    generate
        for (g = 1; g < LEVELS; g++) begin : g_anc
            // R2: a derived level on implies its parent on.
            a_r2_ancestor_on: assert property (@(posedge clk) disable iff (!rst_n)
                gate_chain[g] |-> gate_chain[g-1]);
        end
    endgenerate

    // R3: gate off means every action reports not-ready.
    a_r3_gate_off_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_chain[LEVELS-1] |-> (!enq_ready && !deq_ready && !clr_ready));

    // R3, R5: a dequeue can only be offered when the head is valid.
    a_r3_deq_needs_head: assert property (@(posedge clk) disable iff (!rst_n)
        deq_ready |-> head_valid);

    // R4: gate off freezes the head view across the next edge.
    a_r4_frozen_head: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_chain[LEVELS-1] |=> ($stable(head_valid) && $stable(head_data)));

    // R8: an accepted clear leaves the queue empty.
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && clr_ready) |=> !head_valid);

    // R9: reset leaves the queue empty.
    a_r9_reset_empties: assert property (@(posedge clk)
        !rst_n |=> !head_valid);

endmodule

bind gated_fifo gated_fifo_chk #(.W(W), .DEPTH(DEPTH), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/gated_fifo_test.sv
module gated_fifo_test;

    localparam int W      = 3;
    localparam int DEPTH  = 4;
    localparam int LEVELS = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                base_en = 1'b0;
    logic [LEVELS-1:0]   lvl_en = '0;
    logic                enq_valid = 1'b0;
    logic signed [W-1:0] enq_data = '0;
    logic                enq_ready;
    logic                deq_req = 1'b0;
    logic                deq_ready;
    logic                head_valid;
    logic signed [W-1:0] head_data;
    logic                clr_req = 1'b0;
    logic                clr_ready;
    logic [LEVELS-1:0]   gate_chain;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int model[$];
    string htag = "R9";

    gated_fifo #(.W(W), .DEPTH(DEPTH), .LEVELS(LEVELS)) uut (.*);

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle's inputs, compare outputs, then advance the model.
    task automatic step(bit rn, bit b, bit e0, bit e1, bit ev, int dv, bit dq, bit cl);
        bit g0, g1, g, ef, df;
        rst_n = rn; base_en = b; lvl_en = {e1, e0};
        enq_valid = ev; enq_data = W'(dv); deq_req = dq; clr_req = cl;
        #1;
        g0 = b & e0; g1 = g0 & e1; g = g1;
        chk("R1 gate0", int'(gate_chain[0]), int'(g0));
        chk("R1 gate1", int'(gate_chain[1]), int'(g1));
        if (gate_chain[1]) chk("R2 ancestor", int'(gate_chain[0]), 1);
        chk(model.size() == DEPTH ? "R7 enq_ready" : "R3 enq_ready",
            int'(enq_ready), int'(g && model.size() < DEPTH));
        chk("R3 deq_ready", int'(deq_ready), int'(g && model.size() > 0));
        chk("R3 clr_ready", int'(clr_ready), int'(g));
        chk({htag, " R5 head_valid"}, int'(head_valid), int'(model.size() > 0));
        if (model.size() > 0)
            chk({htag, " R6 head_data"}, int'($signed(head_data)), model[0]);
        @(posedge clk);
        ef = ev && g && model.size() < DEPTH && !cl;
        df = dq && g && model.size() > 0 && !cl;
        if (!rn) begin
            model.delete(); htag = "R9";
        end else if (g && cl) begin
            model.delete(); htag = "R8";
        end else if (!g) begin
            htag = "R4";
        end else begin
            if (df) void'(model.pop_front());
            if (ef) model.push_back(int'($signed(W'(dv))));
            htag = (ef && df) ? "R10" : "R6";
        end
        @(negedge clk);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit [31:0] r = 32'h1234_5678;
        @(negedge clk);
        // R9: reset state, gate on and off.
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 1, 1, 1, 1, 1, 0);
        // R6, R7: fill with signed values including extremes, then overfill.
        step(1, 1, 1, 1, 1, -4, 0, 0);
        step(1, 1, 1, 1, 1, -1, 0, 0);
        step(1, 1, 1, 1, 1, 2, 0, 0);
        step(1, 1, 1, 1, 1, 3, 0, 0);
        step(1, 1, 1, 1, 1, 1, 0, 0);
        // R7: full, enqueue with dequeue only dequeues.
        step(1, 1, 1, 1, 1, 0, 1, 0);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        // R4: each level off in turn with all requests asserted.
        step(1, 1, 1, 0, 1, 1, 1, 1);
        step(1, 1, 0, 1, 1, 1, 1, 1);
        step(1, 0, 1, 1, 1, 1, 1, 1);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        // R10: simultaneous enqueue and dequeue on partial queue.
        step(1, 1, 1, 1, 0, 0, 1, 0);
        step(1, 1, 1, 1, 1, -3, 1, 0);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        // R8: clear beats an enqueue and a dequeue.
        step(1, 1, 1, 1, 1, 2, 1, 1);
        step(1, 1, 1, 1, 1, -2, 0, 0);
        // R9: reset while the gate is off.
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0, 0);
        // Sweep with randomly toggled levels and requests.
        for (int i = 0; i < 4000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            step(r[24:18] != 0, |r[1:0], |r[3:2], |r[5:4], r[6],
                 int'($signed(r[15:13])), r[7], r[12:8] == 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule